// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two 16-bit buses, A and B, and passes data between them without inverting it. Each side has a storage register. The A register holds a snapshot of the A bus, and the B register holds a snapshot of the B bus. The receiving bus is fed from one of two sources: the live value on the opposite bus, or the register that stored that opposite bus earlier. A per-lane select chooses between the two.

The 16 bits form two independent 8-bit lanes. Lane 0 is bits 7:0 and lane 1 is bits 15:8. Each lane has its own controls:
- an active-low output enable;
- a direction bit;
- a capture strobe for each register;
- a source select for each direction.

Tying the two lanes' controls together gives full 16-bit operation.

Each pin is split into an input, an output value and a per-lane drive flag, so that the logic stays synthesizable. The capture strobes are single-bit inputs sampled on the system clock. A register loads on each detected 0-to-1 transition of its strobe, and this happens whatever the enable and direction are.

Each lane decodes its controls into one of three named modes, with no stored state:
- `MODE_ISOLATE`: the output enable is high.
- `MODE_DRIVE_B`: the enable is low and the direction is 1.
- `MODE_DRIVE_A`: the enable is low and the direction is 0.

The mode follows the controls combinationally. Any mode can move to any other as soon as the enable or the direction changes.

Top module: `bus_xcvr16`

## Requirements
- R1: On a system clock edge that sees a lane's `strb_ab` at 1 after it was 0 on the previous edge, that lane's A register loads the lane's `a_in` byte. The new value is visible from that edge on.
- R2: On a system clock edge that sees a lane's `strb_ba` at 1 after it was 0 on the previous edge, that lane's B register loads the lane's `b_in` byte.
- R3: Register loading ignores `oe_n` and `dir`, and it also works in isolation. A strobe held at 1 does not load again.
- R4: With `oe_n`=1, a lane is in `MODE_ISOLATE`: `a_drv` and `b_drv` are both 0, and both output bytes read 0.
- R5: With `oe_n`=0 and `dir`=1, a lane is in `MODE_DRIVE_B`: `b_drv`=1 and `a_drv`=0. With `sel_ab`=0, `b_out` equals the live `a_in`.
- R6: In `MODE_DRIVE_B` with `sel_ab`=1, `b_out` equals the stored A register.
- R7: With `oe_n`=0 and `dir`=0, a lane is in `MODE_DRIVE_A`: `a_drv`=1 and `b_drv`=0. With `sel_ba`=0, `a_out` equals the live `b_in`.
- R8: In `MODE_DRIVE_A` with `sel_ba`=1, `a_out` equals the stored B register.
- R9: `a_drv` and `b_drv` are never both 1 for the same lane.
- R10: The lanes are independent. Control bit i acts only on data bits 8*i+7 down to 8*i.
- R11: An active-low asynchronous `rst_n` clears both registers of every lane to 0.
- R12: When the selected source register loads during stored mode, the driven output changes to the new value from the capturing edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| oe_n | input | 2 | Per-lane output enable, active low |
| dir | input | 2 | Per-lane direction: 1 drives B, 0 drives A |
| strb_ab | input | 2 | Per-lane A register capture strobe |
| strb_ba | input | 2 | Per-lane B register capture strobe |
| sel_ab | input | 2 | Per-lane B-side source: 0 live A, 1 stored A |
| sel_ba | input | 2 | Per-lane A-side source: 0 live B, 1 stored B |
| a_in | input | 16 | A bus input value |
| b_in | input | 16 | B bus input value |
| a_out | output | 16 | Value to drive on A |
| b_out | output | 16 | Value to drive on B |
| a_drv | output | 2 | Per-lane A drive enable |
| b_drv | output | 2 | Per-lane B drive enable |

## Verification
The bench loads a register while the lane is isolated and then reads it back through stored mode. A design that gated loading on the enable would return the old value. It holds a strobe high for several cycles while the input changes. Level-sensitive loading would show up as a later value appearing at the output. It reloads the selected source register while stored mode is active, and it gives the two lanes opposite controls. A lane mix-up or stale stored output would then put the wrong byte on the wrong side. After every stimulus, all four outputs and both drive flags are compared against a reference model, so a direction or select that is swapped or inverted is caught at once.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;
    typedef enum logic [1:0] {
        MODE_ISOLATE = 2'd0,
        MODE_DRIVE_B = 2'd1,
        MODE_DRIVE_A = 2'd2
    } lane_mode_e;
endpackage

// File: rtl/strobe_reg.sv
module strobe_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strb,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic strb_q;
    logic rise;

    assign rise = strb & ~strb_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strb_q <= 1'b0;
            q      <= '0;
        end else begin
            strb_q <= strb;
            if (rise) q <= d;
        end
    end

    // R1 / R2: a detected rising strobe loads the data
    assert_load_on_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (strb && !strb_q) |=> (q == $past(d)));
    // R3: no rise, no change (a held strobe does not reload)
    assert_hold_no_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(strb && !strb_q) |=> $stable(q));
endmodule

// File: rtl/lane_ctrl.sv
module lane_ctrl
    import bus_xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         oe_n,
    input  logic         dir,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic [W-1:0] reg_a,
    input  logic [W-1:0] reg_b,
    output logic [W-1:0] a_out,
    output logic [W-1:0] b_out,
    output logic         a_drv,
    output logic         b_drv
);
    lane_mode_e mode;

    // mode decode
    always_comb begin
        unique case ({oe_n, dir})
            2'b01:   mode = MODE_DRIVE_B;
            2'b00:   mode = MODE_DRIVE_A;
            default: mode = MODE_ISOLATE;
        endcase
    end

    // outputs per mode
    always_comb begin
        a_out = '0;
        b_out = '0;
        a_drv = 1'b0;
        b_drv = 1'b0;
        unique case (mode)
            MODE_DRIVE_B: begin
                b_drv = 1'b1;
                b_out = sel_ab ? reg_a : a_in;
            end
            MODE_DRIVE_A: begin
                a_drv = 1'b1;
                a_out = sel_ba ? reg_b : b_in;
            end
            default: ;
        endcase
    end

    assert_isolate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (!a_drv && !b_drv && a_out == '0 && b_out == '0));
    assert_live_ab_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n && dir && !sel_ab) |-> (b_drv && b_out == a_in));
    assert_stored_ab_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n && dir && sel_ab) |-> (b_drv && b_out == reg_a));
    assert_live_ba_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n && !dir && !sel_ba) |-> (a_drv && a_out == b_in));
    assert_stored_ba_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n && !dir && sel_ba) |-> (a_drv && a_out == reg_b));
endmodule

// File: rtl/bus_xcvr16.sv
module bus_xcvr16 #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LANES-1:0]         oe_n,
    input  logic [LANES-1:0]         dir,
    input  logic [LANES-1:0]         strb_ab,
    input  logic [LANES-1:0]         strb_ba,
    input  logic [LANES-1:0]         sel_ab,
    input  logic [LANES-1:0]         sel_ba,
    input  logic [LANES*LANE_W-1:0]  a_in,
    input  logic [LANES*LANE_W-1:0]  b_in,
    output logic [LANES*LANE_W-1:0]  a_out,
    output logic [LANES*LANE_W-1:0]  b_out,
    output logic [LANES-1:0]         a_drv,
    output logic [LANES-1:0]         b_drv
);
    localparam int BUS_W = LANES * LANE_W;

    logic [BUS_W-1:0] reg_a;
    logic [BUS_W-1:0] reg_b;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam int LO = l * LANE_W;

        strobe_reg #(.W(LANE_W)) u_reg_a (
            .clk  (clk),
            .rst_n(rst_n),
            .strb (strb_ab[l]),
            .d    (a_in[LO +: LANE_W]),
            .q    (reg_a[LO +: LANE_W])
        );

        strobe_reg #(.W(LANE_W)) u_reg_b (
            .clk  (clk),
            .rst_n(rst_n),
            .strb (strb_ba[l]),
            .d    (b_in[LO +: LANE_W]),
            .q    (reg_b[LO +: LANE_W])
        );

        lane_ctrl #(.W(LANE_W)) u_ctrl (
            .clk   (clk),
            .rst_n (rst_n),
            .oe_n  (oe_n[l]),
            .dir   (dir[l]),
            .sel_ab(sel_ab[l]),
            .sel_ba(sel_ba[l]),
            .a_in  (a_in[LO +: LANE_W]),
            .b_in  (b_in[LO +: LANE_W]),
            .reg_a (reg_a[LO +: LANE_W]),
            .reg_b (reg_b[LO +: LANE_W]),
            .a_out (a_out[LO +: LANE_W]),
            .b_out (b_out[LO +: LANE_W]),
            .a_drv (a_drv[l]),
            .b_drv (b_drv[l])
        );

        // R9: one side per lane at most
        assert_one_side_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !(a_drv[l] && b_drv[l]));
    end

    // R11: registers are zero while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_clear_R11: assert (reg_a == '0 && reg_b == '0);
        end
    end
endmodule

// File: tb/tb_bus_xcvr16.sv
module tb_bus_xcvr16;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  oe_n = 2'b11, dir = 2'b00, strb_ab = 2'b00, strb_ba = 2'b00;
    logic [1:0]  sel_ab = 2'b00, sel_ba = 2'b00;
    logic [15:0] a_in = '0, b_in = '0;
    logic [15:0] a_out, b_out;
    logic [1:0]  a_drv, b_drv;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [7:0] m_ra [2];
    logic [7:0] m_rb [2];

    always #5 clk = ~clk;

    bus_xcvr16 dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare every output of both lanes against the model (R4-R10)
    task automatic check_all(input string tag);
        logic [15:0] ea, eb;
        logic [1:0]  da, db;
        #1;
        ea = '0; eb = '0; da = '0; db = '0;
        for (int l = 0; l < 2; l++) begin
            if (!oe_n[l] && dir[l]) begin
                db[l] = 1'b1;
                eb[l*8 +: 8] = sel_ab[l] ? m_ra[l] : a_in[l*8 +: 8];
            end else if (!oe_n[l] && !dir[l]) begin
                da[l] = 1'b1;
                ea[l*8 +: 8] = sel_ba[l] ? m_rb[l] : b_in[l*8 +: 8];
            end
        end
        chk({tag, " a_out"}, 32'(a_out), 32'(ea));
        chk({tag, " b_out"}, 32'(b_out), 32'(eb));
        chk({tag, " a_drv"}, 32'(a_drv), 32'(da));
        chk({tag, " b_drv"}, 32'(b_drv), 32'(db));
        chk({tag, " R9 exclusive"}, 32'(a_drv & b_drv), 32'd0);
    endtask

    task automatic pulse_ab(input int l);
        @(negedge clk); strb_ab[l] = 1'b1;
        @(negedge clk); m_ra[l] = a_in[l*8 +: 8]; strb_ab[l] = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_ba(input int l);
        @(negedge clk); strb_ba[l] = 1'b1;
        @(negedge clk); m_rb[l] = b_in[l*8 +: 8]; strb_ba[l] = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        for (int l = 0; l < 2; l++) begin m_ra[l] = '0; m_rb[l] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        oe_n = 2'b00; dir = 2'b11; sel_ab = 2'b11; a_in = 16'hFFFF;
        check_all("R11 reset A regs zero");
        dir = 2'b00; sel_ba = 2'b11; b_in = 16'hFFFF;
        check_all("R11 reset B regs zero");
    endtask

    task automatic t_isolate_capture();
        oe_n = 2'b11; sel_ab = 2'b00; sel_ba = 2'b00;
        a_in = 16'h5AC3; b_in = 16'h3C96;
        check_all("R4 isolate");
        pulse_ab(0); pulse_ab(1); pulse_ba(0); pulse_ba(1);
        check_all("R3 isolate after load");
        a_in = 16'h0000; b_in = 16'h0000;
        oe_n = 2'b00; dir = 2'b11; sel_ab = 2'b11;
        check_all("R1 R3 stored A loaded in isolation");
        chk("R1 stored A value", 32'(b_out), 32'h5AC3);
        dir = 2'b00; sel_ba = 2'b11;
        check_all("R2 R3 stored B loaded in isolation");
        chk("R2 stored B value", 32'(a_out), 32'h3C96);
    endtask

    task automatic t_live();
        oe_n = 2'b00; dir = 2'b11; sel_ab = 2'b00;
        a_in = 16'h1234; check_all("R5 live A to B p1");
        a_in = 16'hFEDC; check_all("R5 live A to B p2");
        chk("R5 live value", 32'(b_out), 32'hFEDC);
        dir = 2'b00; sel_ba = 2'b00;
        b_in = 16'hA55A; check_all("R7 live B to A p1");
        b_in = 16'h0F0F; check_all("R7 live B to A p2");
        chk("R7 live value", 32'(a_out), 32'h0F0F);
    endtask

    task automatic t_stored();
        oe_n = 2'b00; dir = 2'b11; sel_ab = 2'b11;
        a_in = 16'h7711; pulse_ab(0); pulse_ab(1);
        a_in = 16'h0000;
        check_all("R6 stored A to B");
        chk("R6 stored value", 32'(b_out), 32'h7711);
        dir = 2'b00; sel_ba = 2'b11;
        b_in = 16'h88EE; pulse_ba(0); pulse_ba(1);
        b_in = 16'h1111;
        check_all("R8 stored B to A");
        chk("R8 stored value", 32'(a_out), 32'h88EE);
    endtask

    task automatic t_stored_update();
        oe_n = 2'b00; dir = 2'b11; sel_ab = 2'b11;
        a_in = 16'h4242;
        @(negedge clk); strb_ab[0] = 1'b1;
        @(negedge clk); m_ra[0] = 8'h42;
        check_all("R12 output follows new capture");
        chk("R12 low byte", 32'(b_out[7:0]), 32'h42);
        a_in = 16'h9999;
        repeat (3) @(negedge clk);
        check_all("R3 held strobe no reload");
        chk("R3 held strobe value", 32'(b_out[7:0]), 32'h42);
        strb_ab[0] = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_lanes();
        oe_n = 2'b00; dir = 2'b01; sel_ab = 2'b00; sel_ba = 2'b01;
        a_in = 16'hC0DE; b_in = 16'hBEEF;
        check_all("R10 lane0 to B lane1 to A");
        chk("R10 drive flags", 32'({a_drv, b_drv}), 32'b1001);
        oe_n = 2'b10; dir = 2'b10;
        check_all("R10 lane1 isolated lane0 to A");
        b_in = 16'h00AB; pulse_ba(1);
        oe_n = 2'b01; sel_ba = 2'b11; dir = 2'b00;
        check_all("R10 lane1 stored B to A");
    endtask

    initial begin
        t_reset();
        t_isolate_capture();
        t_live();
        t_stored();
        t_stored_update();
        t_lanes();
        for (int c = 0; c < 64; c++) begin
            oe_n = c[1:0]; dir = c[3:2]; sel_ab = c[5:4]; sel_ba = {c[0], c[5]};
            a_in = 16'(c * 16'h1357); b_in = 16'(c * 16'h2468 + 16'h11);
            check_all("R4 R5 R6 R7 R8 control sweep");
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule